// File: doc/BRIEF.md
# Memory-Based Multi-Tap Delay Line

This block is a tapped delay line for filter and correlation datapaths. Its sample history is held in one memory array, not in one register per stage. Each clock edge with the shift enable high accepts one sample of `SAMPLE_W` bits. After that edge the block presents `TAPS` delayed copies of the input stream. The copies are spaced `SPACING` accepted samples apart and are packed side by side into one output word.

The memory holds `SPACING` lines, and each line carries every tap segment. A wrapping pointer selects one line per accepted sample. In that cycle the line is read, its segments move up by one position with the new sample entering at the bottom, and the result is written back to the same line.

The elaborated size is limited in two ways, and a configuration outside either limit stops elaboration. A longer line is built by chaining instances: the oldest tap and the delayed enable of one instance drive the data and enable inputs of the next.

Top module: `mem_tap_line`

## Requirements
- R1: While `rst_n` is low at a clock edge, `taps_o`, `valid_o` and `cascade_en_o` are all zero after that edge. Once reset is released, filling starts again from an empty history.
- R2: After an edge that accepts a sample (`shift_en` high), segment k of `taps_o` holds the sample accepted (k+1)·`SPACING` accepted samples before the current one. Segment k occupies bits [(k+1)·`SAMPLE_W`−1 : k·`SAMPLE_W`], with segment 0 as the least significant. The result appears in the cycle that directly follows that edge.
- R3: `valid_o` stays low until `SPACING`·`TAPS` samples have been accepted since reset. It goes high after the edge that accepts the next sample, and it then stays high until reset.
- R4: While `valid_o` is low, `taps_o` reads all zeros.
- R5: An edge with `shift_en` low leaves `taps_o` and `valid_o` unchanged. The `sample_i` value at such an edge never enters the history.
- R6: `cascade_o` always equals the highest segment of `taps_o`. `cascade_en_o` is high exactly in the cycle after an edge that accepted a sample. Feeding both into a second instance gives a delay line that is twice as long.
- R7: Elaboration fails if `SAMPLE_W`·`SPACING`·`TAPS` exceeds 9216 or if `SAMPLE_W`·`TAPS` exceeds 36. A configuration that sits exactly on the width limit and uses a deep memory works as R2–R5 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Accept `sample_i` at this edge and advance the line |
| sample_i | input | SAMPLE_W | New sample |
| taps_o | output | SAMPLE_W·TAPS | Packed tap word, segment 0 in the low bits |
| valid_o | output | 1 | All taps hold samples accepted since reset |
| cascade_o | output | SAMPLE_W | Oldest tap, for chaining |
| cascade_en_o | output | 1 | Enable for a chained instance |

## Verification
Three patterns of `shift_en` are used: random gaps, an unbroken run, and a sparse run in which most edges are idle. Every cycle, each output is compared with a value computed from the index of the accepted sample. Because of the random gaps, a design that shifts on every edge gives wrong taps, and the junk data driven on idle edges exposes any sample that leaks into the history. The unbroken run checks the pointer wrap and the read-before-write at each line. Three instances are driven together: a small configuration, a second instance chained behind it, and an instance at the 36-bit width limit with a 256-line memory, and a reset in the middle of the run shows that filling starts over.

// File: rtl/tapline_pkg.sv
// Package: capacity limits and shared helpers for the memory-based delay line.
// Assumes: limits describe one memory block of the target fabric.
package tapline_pkg;
    localparam int unsigned MAX_BITS  = 9216;
    localparam int unsigned MAX_WIDTH = 36;

    // Address width for a memory of the given depth, never below one bit.
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/tapline_ptr.sv
// Module: tapline_ptr
// Wrapping line pointer. Moves forward by one on each advance and returns to
// zero after DEPTH-1. Assumes DEPTH >= 1; for DEPTH == 1 it stays at zero.
module tapline_ptr #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = tapline_pkg::addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // Step the pointer on each advance, wrapping modulo DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tapline_ram.sv
// Module: tapline_ram
// Single-clock memory with one shared address, an asynchronous read and a
// synchronous write. The read returns the stored line before this edge's
// write, so a read and a write at the same address see the old data.
// Assumes no reset of the contents; the owner hides stale lines.
module tapline_ram #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned WORD_W = 8,
    parameter int unsigned ADDR_W = tapline_pkg::addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Old contents of the addressed line.
    assign rdata = mem[addr];

    // Store the new line at the clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/tapline_fill.sv
// Module: tapline_fill
// Saturating count of the samples accepted since reset. full is high once
// TARGET samples have been counted. Assumes TARGET >= 1.
module tapline_fill #(
    parameter int unsigned TARGET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic full
);
    localparam int unsigned CW = $clog2(TARGET + 1);
    localparam logic [CW-1:0] TOP = CW'(TARGET);

    logic [CW-1:0] cnt;

    // Count accepted samples until the history is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == TOP);
endmodule

// File: rtl/mem_tap_line.sv
// Module: mem_tap_line
// Tapped delay line held in one memory array. The memory has SPACING lines of
// SAMPLE_W*TAPS bits. Each accepted sample reads the line at the wrapping
// pointer, moves its segments up by one with the new sample at the bottom, and
// writes it back. The old line goes to a registered tap word, so segment k
// shows the sample from (k+1)*SPACING accepted samples earlier. The taps stay
// zero until the whole history has been written since reset.
// Assumes: one clock, synchronous active-low reset, sizes within one memory block.
module mem_tap_line #(
    parameter int unsigned SAMPLE_W = 4,
    parameter int unsigned SPACING  = 5,
    parameter int unsigned TAPS     = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic [SAMPLE_W-1:0]          sample_i,
    output logic [SAMPLE_W*TAPS-1:0]     taps_o,
    output logic                         valid_o,
    output logic [SAMPLE_W-1:0]          cascade_o,
    output logic                         cascade_en_o
);
    localparam int unsigned WORD_W = SAMPLE_W * TAPS;
    localparam int unsigned BITS   = WORD_W * SPACING;
    localparam int unsigned FILL   = SPACING * TAPS;
    localparam int unsigned ADDR_W = tapline_pkg::addr_bits(SPACING);

    // Capacity checks at elaboration.
    if (BITS > tapline_pkg::MAX_BITS) begin : g_too_many_bits
        $error("mem_tap_line: storage of %0d bits exceeds the block limit", BITS);
    end
    if (WORD_W > tapline_pkg::MAX_WIDTH) begin : g_too_wide
        $error("mem_tap_line: tap word of %0d bits exceeds the width limit", WORD_W);
    end
    if (SAMPLE_W == 0 || SPACING == 0 || TAPS == 0) begin : g_empty
        $error("mem_tap_line: every size parameter must be at least one");
    end

    logic [ADDR_W-1:0] line_ptr;
    logic [WORD_W-1:0] old_line;
    logic [WORD_W-1:0] new_line;
    logic              hist_full;
    logic [WORD_W-1:0] taps_q;
    logic              valid_q;
    logic              casc_en_q;

    tapline_ptr #(
        .DEPTH  (SPACING),
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .ptr   (line_ptr)
    );

    tapline_ram #(
        .DEPTH  (SPACING),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .addr  (line_ptr),
        .we    (shift_en),
        .wdata (new_line),
        .rdata (old_line)
    );

    tapline_fill #(
        .TARGET (FILL)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .full  (hist_full)
    );

    // Line to write back: older segments move up, the new sample enters at segment 0.
    if (TAPS > 1) begin : g_shift
        assign new_line = {old_line[WORD_W-SAMPLE_W-1:0], sample_i};
    end else begin : g_single
        assign new_line = sample_i;
    end

    // Register the old line as the tap word once the history is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_q  <= '0;
            valid_q <= 1'b0;
        end else if (shift_en) begin
            taps_q  <= hist_full ? old_line : '0;
            valid_q <= hist_full;
        end
    end

    // Delay the enable by one cycle so a chained instance sees each new oldest tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            casc_en_q <= 1'b0;
        end else begin
            casc_en_q <= shift_en;
        end
    end

    assign taps_o       = taps_q;
    assign valid_o      = valid_q;
    assign cascade_o    = taps_q[WORD_W-1 -: SAMPLE_W];
    assign cascade_en_o = casc_en_q;
endmodule

// File: rtl/tapline_chk.sv
// Module: tapline_chk
// Port-level temporal checks for mem_tap_line, attached with bind.
module tapline_chk #(
    parameter int unsigned SAMPLE_W = 4,
    parameter int unsigned TAPS     = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     shift_en,
    input logic [SAMPLE_W*TAPS-1:0] taps_o,
    input logic                     valid_o,
    input logic                     cascade_en_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (taps_o == '0 && !valid_o && !cascade_en_o)); // R1
    AST_VALID_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid_o) |-> $past(shift_en)); // R3
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> valid_o); // R3
    AST_ZERO_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> taps_o == '0); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !shift_en |=> ($stable(taps_o) && $stable(valid_o))); // R5
    AST_CASCADE_EN_ON: assert property (@(posedge clk) disable iff (!rst_n) shift_en |=> cascade_en_o); // R6
    AST_CASCADE_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !shift_en |=> !cascade_en_o); // R6
endmodule

bind mem_tap_line tapline_chk #(
    .SAMPLE_W (SAMPLE_W),
    .TAPS     (TAPS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (shift_en),
    .taps_o       (taps_o),
    .valid_o      (valid_o),
    .cascade_en_o (cascade_en_o)
);

// File: tb/sim_mem_tap_line.sv
module sim_mem_tap_line;
    localparam int CLK_P = 10;
    localparam int W0 = 4,  M0 = 5,   N0 = 3;
    localparam int W1 = 12, M1 = 256, N1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic [W0-1:0] s0 = '0;
    logic [W1-1:0] s1 = '0;

    logic [W0*N0-1:0] t0, t2;
    logic [W1*N1-1:0] t1;
    logic v0, v1, v2, ce0, ce1, ce2;
    logic [W0-1:0] c0o, c2o;
    logic [W1-1:0] c1o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mem_tap_line #(.SAMPLE_W(W0), .SPACING(M0), .TAPS(N0)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sample_i(s0),
        .taps_o(t0), .valid_o(v0), .cascade_o(c0o), .cascade_en_o(ce0));
    mem_tap_line #(.SAMPLE_W(W1), .SPACING(M1), .TAPS(N1)) u1 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sample_i(s1),
        .taps_o(t1), .valid_o(v1), .cascade_o(c1o), .cascade_en_o(ce1));
    mem_tap_line #(.SAMPLE_W(W0), .SPACING(M0), .TAPS(N0)) u2 (
        .clk(clk), .rst_n(rst_n), .shift_en(ce0), .sample_i(c0o),
        .taps_o(t2), .valid_o(v2), .cascade_o(c2o), .cascade_en_o(ce2));

    // Sample value for accepted index idx.
    function automatic int fv(int idx, int salt, int w);
        return (idx * 37 + salt * 11 + 3 + (idx >> 3) * 5) & ((1 << w) - 1);
    endfunction

    // Sample entering the chained instance as its j-th accepted input.
    function automatic int casc_in(int j);
        return (j >= M0 * N0) ? fv(j - M0 * N0, 0, W0) : 0;
    endfunction

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model state.
    int cnt0 = 0;
    int cnt2 = 0;
    logic [W0*N0-1:0] e0 = '0, e2 = '0;
    logic [W1*N1-1:0] e1 = '0;
    logic ev0 = 1'b0, ev1 = 1'b0, ev2 = 1'b0;
    bit en_last = 1'b0;

    // One clock: drive at the falling edge, check at the next falling edge.
    task automatic step(bit en_in, bit rst_in);
        bit u2_en;
        string tg0, tg1, tg2;
        shift_en = en_in;
        rst_n = !rst_in;
        if (en_in) begin
            s0 = W0'(fv(cnt0, 0, W0));
            s1 = W1'(fv(cnt0, 2, W1));
        end else begin
            s0 = W0'($urandom);
            s1 = W1'($urandom);
        end
        @(posedge clk);
        @(negedge clk);
        u2_en = en_last;
        if (rst_in) begin
            cnt0 = 0; cnt2 = 0;
            e0 = '0; e1 = '0; e2 = '0;
            ev0 = 1'b0; ev1 = 1'b0; ev2 = 1'b0;
            en_last = 1'b0;
            cmp("R1", "u0 taps", 64'(t0), 64'(0));
            cmp("R1", "u0 valid", 64'(v0), 64'(0));
            cmp("R1", "u0 cascade_en", 64'(ce0), 64'(0));
            cmp("R1", "u1 taps", 64'(t1), 64'(0));
            cmp("R1", "u1 valid", 64'(v1), 64'(0));
            return;
        end
        if (en_in) begin
            ev0 = (cnt0 >= M0 * N0);
            ev1 = (cnt0 >= M1 * N1);
            for (int k = 0; k < N0; k++)
                e0[k*W0 +: W0] = ev0 ? W0'(fv(cnt0 - (k + 1) * M0, 0, W0)) : '0;
            for (int k = 0; k < N1; k++)
                e1[k*W1 +: W1] = ev1 ? W1'(fv(cnt0 - (k + 1) * M1, 2, W1)) : '0;
            cnt0++;
        end
        if (u2_en) begin
            ev2 = (cnt2 >= M0 * N0);
            for (int k = 0; k < N0; k++)
                e2[k*W0 +: W0] = ev2 ? W0'(casc_in(cnt2 - (k + 1) * M0)) : '0;
            cnt2++;
        end
        en_last = en_in;
        tg0 = !en_in ? "R5" : (ev0 ? "R2" : "R4");
        tg1 = !en_in ? "R5" : "R7";
        tg2 = !u2_en ? "R5" : "R6";
        cmp(tg0, "u0 taps", 64'(t0), 64'(e0));
        cmp("R3", "u0 valid", 64'(v0), 64'(ev0));
        cmp(tg1, "u1 taps", 64'(t1), 64'(e1));
        cmp("R7", "u1 valid", 64'(v1), 64'(ev1));
        cmp(tg2, "u2 taps", 64'(t2), 64'(e2));
        cmp("R6", "u2 valid", 64'(v2), 64'(ev2));
        cmp("R6", "u0 cascade_o", 64'(c0o), 64'(e0[W0*N0-1 -: W0]));
        cmp("R6", "u0 cascade_en", 64'(ce0), 64'(en_in));
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);         // R1 reset
        for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, 1'b0);
        for (int i = 0; i < 600; i++) step(1'b1, 1'b0);        // unbroken run
        for (int i = 0; i < 400; i++) step(($urandom % 10) == 0, 1'b0);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1);          // R1 mid-run reset
        for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule